// File: doc/BRIEF.md
# Programmable Pulse Generator Sequencer

This block produces timed pulse cycles for a digital test-signal source. Every cycle opens with a one-clock synchronisation strobe. After a programmable delay it drives a main pulse of programmable width. The main pulse appears on a true output and on a complementary output. In double mode, a second main pulse of the same width is added at the very start of the cycle. All durations are counted in clock cycles.

A cycle can be launched in four ways, chosen by a mode input:
- a free-running internal repetition timer;
- a rising edge on an asynchronous external trigger;
- a one-clock manual request;
- the internal timer, but only while a gate input is held high.

Any trigger that arrives while a cycle is running is dropped. The configuration may ask for a delay plus width that does not fit in the period. In that case an error flag rises and the cycle is lengthened so that the main pulse still completes.

Top module: `pgen_top`

## Requirements
- R1: While rst_n is low and after its release, sync_o and pulse_p_o are low and pulse_n_o is high, until a cycle starts.
- R2: A cycle lasts L clocks, where L is cfg_period_i, or cfg_delay_i+cfg_width_i+1 when the period is too short (see R11). Its phases are numbered 0..L-1, and sync_o is high exactly in phase 0.
- R3: pulse_p_o is high in the phases p with cfg_delay_i <= p < cfg_delay_i+cfg_width_i. A width of zero gives no main pulse.
- R4: pulse_n_o is always the inverse of pulse_p_o.
- R5: With cfg_double_i high, pulse_p_o is also high in the phases p < cfg_width_i. Overlapping pulses merge into one.
- R6: In internal mode, a cycle starts on the first clock edge after the mode is selected while idle, and cycles then follow back to back with no idle clock.
- R7: In external mode, a cycle starts at edge k+2 when ext_trig_i is sampled low at edge k-1 and high at edge k (two synchronising flops plus a rising-edge detector).
- R8: In manual mode, man_req_i sampled high at an edge while idle starts a cycle at that edge.
- R9: A trigger (external edge or manual request) that arrives while a cycle is running is dropped. It neither restarts nor queues a cycle.
- R10: In gated mode, a cycle starts from idle, or follows the previous one, only when gate_i is high at that edge. A running cycle finishes even if gate_i falls.
- R11: cfg_err_o is high exactly when cfg_delay_i+cfg_width_i >= cfg_period_i. The cycle length is then cfg_delay_i+cfg_width_i+1.
- R12: cfg_mode_i encodes 0 off, 1 internal, 2 external, 3 manual and 4 gated, and any other value acts as off. In off mode no cycle starts, and a running cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 3 | Trigger source select |
| cfg_double_i | input | 1 | Double-pulse enable |
| cfg_period_i | input | CNT_W | Repetition period in clocks |
| cfg_delay_i | input | CNT_W | Delay from sync strobe to main pulse |
| cfg_width_i | input | CNT_W | Main pulse width |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| gate_i | input | 1 | Gate for gated mode |
| man_req_i | input | 1 | One-clock manual request |
| sync_o | output | 1 | Cycle synchronisation strobe |
| pulse_p_o | output | 1 | Main pulse, true polarity |
| pulse_n_o | output | 1 | Main pulse, inverted polarity |
| cfg_err_o | output | 1 | Delay plus width does not fit the period |

## Verification
The bench aims at the following corner cases:
- A second external rising edge inside a busy cycle. A design that retriggers would show an early second sync strobe.
- A manual request while busy. A design that queues it would start an extra cycle afterwards.
- A gate that falls mid-cycle. A design that aborts would truncate the main pulse, and one that ignores the gate would keep cycling.
- An over-long delay plus width. A design without stretching would cut the pulse or wrap early.
- Zero width, and double pulses that overlap the delayed pulse. A design that gets these wrong would produce a stray or split pulse.
- Leaving internal mode mid-cycle. The cycle must finish with no new strobe.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_INT  = 3'd1,
    MODE_EXT  = 3'd2,
    MODE_MAN  = 3'd3,
    MODE_GATE = 3'd4
  } pgen_mode_e;
endpackage

// File: rtl/pgen_trig_sync.sv
module pgen_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = async_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pgen_len.sv
module pgen_len #(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [PH_W-1:0]  span_o,
  output logic [PH_W-1:0]  len_o,
  output logic             err_o
);
  always_comb begin
    span_o = {1'b0, delay_i} + {1'b0, width_i};
    err_o  = span_o >= {1'b0, period_i};
    len_o  = err_o ? span_o + PH_W'(1) : {1'b0, period_i};
  end
endmodule

// File: rtl/pgen_seq.sv
module pgen_seq
  import pgen_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pgen_mode_e      mode_i,
  input  logic            gate_i,
  input  logic            ext_rise_i,
  input  logic            man_req_i,
  input  logic [PH_W-1:0] len_i,
  output logic            active_o,
  output logic [PH_W-1:0] phase_o
);
  logic            act_q, act_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            last, rearm, start, upd;

  always_comb begin
    last  = ph_q >= (len_i - PH_W'(1));
    rearm = (mode_i == MODE_INT) || ((mode_i == MODE_GATE) && gate_i);
    start = rearm || ((mode_i == MODE_EXT) && ext_rise_i) ||
            ((mode_i == MODE_MAN) && man_req_i);
    upd   = act_q | start;
    act_d = act_q;
    ph_d  = ph_q;
    if (act_q) begin
      if (last) begin
        ph_d = '0;
        if (!rearm) act_d = 1'b0;
      end else begin
        ph_d = ph_q + PH_W'(1);
      end
    end else if (start) begin
      act_d = 1'b1;
      ph_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
    end else if (upd) begin
      act_q <= act_d;
      ph_q  <= ph_d;
    end
  end

  assign active_o = act_q;
  assign phase_o  = ph_q;

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && ((ph_q + PH_W'(1)) < len_i)) |=> (act_q && ph_q != '0));

  p_gate_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_GATE && act_q && last && !gate_i) |=> !act_q);

  p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && mode_i == MODE_OFF) |=> !act_q);
endmodule

// File: rtl/pgen_shape.sv
module pgen_shape #(
  parameter int CNT_W = 16,
  localparam int PH_W = CNT_W + 1
) (
  input  logic             active_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic [PH_W-1:0]  span_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic             double_i,
  output logic             sync_o,
  output logic             pos_o,
  output logic             neg_o
);
  logic in_main, in_first;

  always_comb begin
    in_main  = (phase_i >= {1'b0, delay_i}) && (phase_i < span_i);
    in_first = double_i && (phase_i < {1'b0, width_i});
    sync_o   = active_i && (phase_i == '0);
    pos_o    = active_i && (in_main || in_first);
    neg_o    = ~pos_o;
  end
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_double_i,
  input  logic [CNT_W-1:0] cfg_period_i,
  input  logic [CNT_W-1:0] cfg_delay_i,
  input  logic [CNT_W-1:0] cfg_width_i,
  input  logic             ext_trig_i,
  input  logic             gate_i,
  input  logic             man_req_i,
  output logic             sync_o,
  output logic             pulse_p_o,
  output logic             pulse_n_o,
  output logic             cfg_err_o
);
  localparam int PH_W = CNT_W + 1;

  pgen_mode_e      mode;
  logic            ext_rise;
  logic [PH_W-1:0] span, len, phase;
  logic            active;

  assign mode = pgen_mode_e'(cfg_mode_i);

  pgen_trig_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_trig_i), .rise_o(ext_rise)
  );

  pgen_len #(.CNT_W(CNT_W)) u_len (
    .period_i(cfg_period_i), .delay_i(cfg_delay_i), .width_i(cfg_width_i),
    .span_o(span), .len_o(len), .err_o(cfg_err_o)
  );

  pgen_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .gate_i(gate_i),
    .ext_rise_i(ext_rise), .man_req_i(man_req_i), .len_i(len),
    .active_o(active), .phase_o(phase)
  );

  pgen_shape #(.CNT_W(CNT_W)) u_shape (
    .active_i(active), .phase_i(phase), .span_i(span),
    .delay_i(cfg_delay_i), .width_i(cfg_width_i), .double_i(cfg_double_i),
    .sync_o(sync_o), .pos_o(pulse_p_o), .neg_o(pulse_n_o)
  );

  p_ext_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_EXT && !active && ext_rise) |=> sync_o);

  p_man_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MAN && !active && man_req_i) |=> sync_o);

  p_stretch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (phase + PH_W'(1)) == len) |->
      (phase >= ({1'b0, cfg_delay_i} + {1'b0, cfg_width_i})));
endmodule

// File: tb/tb_pgen_top.sv
`timescale 1ns/1ps
module tb_pgen_top;
  localparam int W = 16;
  localparam logic [2:0] M_OFF = 3'd0, M_INT = 3'd1, M_EXT = 3'd2,
                         M_MAN = 3'd3, M_GATE = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = M_OFF;
  logic dbl = 1'b0;
  logic [W-1:0] per = 16'd10, dly = 16'd2, wid = 16'd2;
  logic ext = 1'b0, gate = 1'b0, man = 1'b0;
  logic sync_o, pulse_p_o, pulse_n_o, cfg_err_o;

  int checks = 0, failures = 0, sync_cnt = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int m_act = 0, m_ph = 0, m_len = 0;
  bit e1 = 0, e2 = 0, e3 = 0, m_rise = 0, m_rearm = 0, m_start = 0;

  always #4 clk = ~clk;

  pgen_top #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode_i(mode), .cfg_double_i(dbl),
    .cfg_period_i(per), .cfg_delay_i(dly), .cfg_width_i(wid),
    .ext_trig_i(ext), .gate_i(gate), .man_req_i(man),
    .sync_o(sync_o), .pulse_p_o(pulse_p_o), .pulse_n_o(pulse_n_o),
    .cfg_err_o(cfg_err_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_ph = 0; e1 = 0; e2 = 0; e3 = 0;
    end else begin
      m_len   = (int'(dly) + int'(wid) >= int'(per)) ? int'(dly) + int'(wid) + 1 : int'(per);
      m_rise  = e2 && !e3;
      e3 = e2; e2 = e1; e1 = ext;
      m_rearm = (mode == M_INT) || (mode == M_GATE && gate);
      m_start = m_rearm || (mode == M_EXT && m_rise) || (mode == M_MAN && man);
      if (m_act != 0) begin
        if (m_ph >= m_len - 1) begin
          m_ph = 0;
          if (!m_rearm) m_act = 0;
        end else m_ph++;
      end else if (m_start) begin
        m_act = 1; m_ph = 0;
      end
    end
  end

  task automatic chk(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit es, ep, ee;
    es = (m_act != 0) && (m_ph == 0);
    ep = (m_act != 0) && ((m_ph >= int'(dly) && m_ph < int'(dly) + int'(wid)) ||
                          (dbl && m_ph < int'(wid)));
    ee = int'(dly) + int'(wid) >= int'(per);
    chk((cur_req == "R1") ? "R1" : "R2", "sync_o", sync_o, es);
    chk(cur_req, "pulse_p_o", pulse_p_o, ep);
    chk("R4", "pulse_n_o", pulse_n_o, ~ep);
    chk("R11", "cfg_err_o", cfg_err_o, ee);
    if (sync_o) sync_cnt++;
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic setup(string req, logic [2:0] m, int p, int d, int w, bit db);
    mode = M_OFF; tick(20);
    cur_req = req; per = W'(p); dly = W'(d); wid = W'(w); dbl = db; mode = m;
  endtask

  task automatic cnt_eq(string req, int exp);
    checks++;
    if (sync_cnt != exp) begin
      failures++;
      $display("FAIL %s sync count actual=%0d expected=%0d", req, sync_cnt, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1'b1; tick(5);
    cur_req = "R12"; tick(5);
    setup("R3", M_INT, 10, 3, 2, 0); tick(35);
    setup("R6", M_INT, 7, 0, 3, 0); tick(25);
    setup("R3", M_INT, 6, 2, 0, 0); tick(15);
    setup("R5", M_INT, 12, 5, 2, 1); tick(40);
    setup("R5", M_INT, 9, 1, 3, 1); tick(30);
    setup("R7", M_EXT, 8, 2, 3, 0);
    ext = 1; tick(3); ext = 0; tick(15);
    cur_req = "R9"; sync_cnt = 0;
    ext = 1; tick(3); ext = 0; tick(1); ext = 1; tick(20);
    cnt_eq("R9", 1); ext = 0;
    setup("R8", M_MAN, 6, 1, 2, 0);
    man = 1; tick(1); man = 0; tick(2);
    cur_req = "R9"; sync_cnt = 0;
    man = 1; tick(1); man = 0; tick(10);
    cnt_eq("R9", 0);
    cur_req = "R8"; man = 1; tick(1); man = 0; tick(10);
    setup("R10", M_GATE, 8, 2, 2, 0);
    gate = 1; tick(20); gate = 0; tick(20);
    gate = 1; tick(3); gate = 0; tick(15);
    setup("R11", M_INT, 4, 3, 2, 0); tick(30);
    setup("R12", M_INT, 10, 2, 3, 0); tick(4);
    mode = M_OFF; sync_cnt = 0; tick(20);
    cnt_eq("R12", 0);
    mode = 3'd6; tick(10);
    cnt_eq("R12", 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule